// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. Software reaches it through a byte-wide write port with one address bit (port 0 and port 1). After reset the controller stays silent until it has taken an initialisation sequence. That sequence sets the trigger mode, the vector base, the cascade arrangement and the processor mode. From then on, port 1 loads the interrupt mask and port 0 accepts the end-of-interrupt command.

The controller holds a request latch per line, an in-service register and a mask register. Priority is fixed, with line 0 the most urgent. When the processor pulses the acknowledge input, the winning request moves into service. One cycle later the block returns an 8-bit vector. If the winning line is marked as feeding a downstream controller, the block instead names that line on a cascade-select output. A separate trigger-control register picks edge or level sensing for each line.

Top module: `pic8_core`

## Requirements
- R1: Initialisation starts with a port 0 write that has bit 4 set (the start word). The next port 1 writes are taken in order as the base word, then the cascade word (only when start bit 1 is 0), then the mode word (only when start bit 0 is 1). The controller is ready after the last of these. Until it is ready, int_out stays low, and port 0 writes with bit 4 clear have no effect.
- R2: A start word clears the mask, the in-service register and every edge request latch.
- R3: One cycle after an acknowledge that takes a request on line i, vec_valid is high for one cycle and vec_out equals (base word AND 0xF8) OR i.
- R4: Among requests that are pending and not masked, the lowest-numbered line wins, with line 0 the highest priority.
- R5: After ready, a port 1 write loads the mask, and a 1 bit blocks that line. An edge that arrives on a masked line is still latched, and it is presented once the line is unmasked.
- R6: A request is presented on int_out only if its line has a higher priority than every bit set in the in-service register.
- R7: After ready, a port 0 write of exactly 0x20 clears the highest-priority set in-service bit. Other port 0 values with bit 4 clear leave the in-service register unchanged.
- R8: An edge line latches a request on a 0-to-1 transition, and an acknowledge of that line clears the latch. An input held high produces no new request.
- R9: A trigger-control write (trig_we, accepted at any time) sets bit i to 1 to make line i level-sensed. A level request follows the input and is gone if the input falls before the acknowledge. Start word bit 3 makes every line level-sensed.
- R10: An acknowledge taken while no request is presented returns the vector base OR 7 and leaves the in-service register unchanged.
- R11: In cascade mode (start bit 1 = 0), the cascade word is a bitmap of lines that feed downstream controllers. An acknowledge of such a line pulses cas_active for one cycle with cas_sel equal to the line, keeps vec_valid low, and still sets the in-service bit. In single mode the cascade word is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Port select (0 or 1) |
| wr_data | input | 8 | Write data |
| trig_we | input | 1 | Trigger-control register write strobe |
| trig_data | input | 8 | Trigger-control data, 1 = level-sensed |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | vec_out holds a fresh vector |
| vec_out | output | 8 | Returned vector |
| cas_active | output | 1 | Acknowledge routed to a downstream controller |
| cas_sel | output | 3 | Line index of the routed downstream controller |

## Verification
The bench targets several corner cases, and each one shows up as a specific wrong behaviour in a faulty design.

- A stray command word in the middle of initialisation: a faulty state machine would go out of step and take the wrong byte as the vector base.
- An input still held high when a start word clears the latches: a faulty design would raise a phantom request.
- A lower line arriving while a higher one is in service: a faulty design would nest it when it must be held back.
- A non-EOI command word: a faulty design would release the in-service bit.
- A level line that drops before the acknowledge: a faulty design would leave a stale request.
- An acknowledge with nothing pending: a faulty design would return a wrong default vector.
- An acknowledge of a cascade line: a faulty design would produce a vector instead of a cascade selection.

Random traffic then compares every cycle against a reference model kept in the bench.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NIRQ = 8;
  localparam int IDXW = $clog2(NIRQ);
  localparam logic [7:0] BASE_MASK = 8'hFF << IDXW;
  localparam logic [7:0] EOI_CODE  = 8'h20;
  localparam int START_BIT = 4;

  typedef enum logic [2:0] {
    INIT_WAIT, INIT_BASE, INIT_CASC, INIT_MODE, INIT_DONE
  } init_st_e;

  // index of the lowest set bit, NIRQ when none is set
  function automatic logic [IDXW:0] first_set(input logic [NIRQ-1:0] v);
    logic [IDXW:0] r;
    r = (IDXW+1)'(NIRQ);
    for (int i = NIRQ-1; i >= 0; i--) begin
      if (v[i]) r = (IDXW+1)'(i);
    end
    return r;
  endfunction

  function automatic logic [NIRQ-1:0] onehot_of(input logic [IDXW-1:0] idx);
    return NIRQ'(1) << idx;
  endfunction
endpackage

// File: rtl/pic8_init.sv
module pic8_init
  import pic8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [7:0]      wr_data,
  output logic            ready,
  output logic            init_clr,
  output logic [7:0]      vec_base,
  output logic [NIRQ-1:0] slave_map,
  output logic            single_mode,
  output logic            level_all
);
  init_st_e st;
  logic     need_mode;

  assign init_clr = wr_en && !wr_addr && wr_data[START_BIT];
  assign ready    = (st == INIT_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= INIT_WAIT;
      need_mode   <= 1'b0;
      single_mode <= 1'b0;
      level_all   <= 1'b0;
      vec_base    <= '0;
      slave_map   <= '0;
    end else if (init_clr) begin
      st          <= INIT_BASE;
      single_mode <= wr_data[1];
      need_mode   <= wr_data[0];
      level_all   <= wr_data[3];
    end else if (wr_en && wr_addr) begin
      case (st)
        INIT_BASE: begin
          vec_base <= wr_data & BASE_MASK;
          st <= !single_mode ? INIT_CASC : (need_mode ? INIT_MODE : INIT_DONE);
        end
        INIT_CASC: begin
          slave_map <= wr_data[NIRQ-1:0];
          st <= need_mode ? INIT_MODE : INIT_DONE;
        end
        INIT_MODE: st <= INIT_DONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic8_req.sv
module pic8_req
  import pic8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] level_sel,
  input  logic [NIRQ-1:0] ack_clr,
  output logic [NIRQ-1:0] req
);
  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    logic prev, lat, rise;
    assign rise = irq_in[g] && !prev && !level_sel[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev <= 1'b0;
        lat  <= 1'b0;
      end else begin
        prev <= irq_in[g];
        lat  <= clr ? 1'b0 : ((lat && !ack_clr[g]) || rise);
      end
    end
    assign req[g] = level_sel[g] ? irq_in[g] : lat;
  end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
  import pic8_pkg::*;
(
  input  logic [NIRQ-1:0] req,
  input  logic [NIRQ-1:0] imr,
  input  logic [NIRQ-1:0] isr,
  output logic [IDXW-1:0] pend_idx,
  output logic [IDXW:0]   svc_top,
  output logic            present
);
  logic [IDXW:0] pend_full;
  assign pend_full = first_set(req & ~imr);
  assign svc_top   = first_set(isr);
  assign pend_idx  = pend_full[IDXW-1:0];
  assign present   = !pend_full[IDXW] && (pend_full < svc_top);
endmodule

// File: rtl/pic8_core.sv
module pic8_core
  import pic8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       trig_we,
  input  logic [7:0] trig_data,
  input  logic [7:0] irq_in,
  input  logic       inta,
  output logic       int_out,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  output logic       cas_active,
  output logic [2:0] cas_sel
);
  logic            ready, init_clr, single_mode, level_all;
  logic [7:0]      vec_base;
  logic [NIRQ-1:0] slave_map, lvl_reg, level_sel, req, imr, isr;
  logic [NIRQ-1:0] ack_onehot, eoi_clr;
  logic [IDXW-1:0] pend_idx, lo_idx;
  logic [IDXW:0]   svc_top;
  logic            present, ack_take, ack_hit, to_slave, eoi_req, mask_wr;

  pic8_init u_init (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(ready), .init_clr(init_clr), .vec_base(vec_base), .slave_map(slave_map),
    .single_mode(single_mode), .level_all(level_all)
  );

  assign level_sel = lvl_reg | {NIRQ{level_all}};

  pic8_req u_req (
    .clk(clk), .rst_n(rst_n), .clr(init_clr), .irq_in(irq_in),
    .level_sel(level_sel), .ack_clr(ack_onehot), .req(req)
  );

  pic8_prio u_prio (
    .req(req), .imr(imr), .isr(isr),
    .pend_idx(pend_idx), .svc_top(svc_top), .present(present)
  );

  // named command events
  assign mask_wr    = ready && wr_en && wr_addr;
  assign eoi_req    = ready && wr_en && !wr_addr && (wr_data == EOI_CODE);
  assign ack_take   = ready && inta;
  assign ack_hit    = ack_take && present;
  assign to_slave   = !single_mode && slave_map[pend_idx];
  assign ack_onehot = ack_hit ? onehot_of(pend_idx) : '0;
  assign eoi_clr    = (eoi_req && !svc_top[IDXW]) ? onehot_of(svc_top[IDXW-1:0]) : '0;
  assign lo_idx     = ack_hit ? pend_idx : IDXW'(NIRQ-1);
  assign int_out    = ready && present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr        <= '0;
      isr        <= '0;
      lvl_reg    <= '0;
      vec_valid  <= 1'b0;
      vec_out    <= '0;
      cas_active <= 1'b0;
      cas_sel    <= '0;
    end else begin
      if (trig_we) lvl_reg <= trig_data;
      if (init_clr) begin
        imr <= '0;
        isr <= '0;
      end else begin
        if (mask_wr) imr <= wr_data;
        isr <= (isr & ~eoi_clr) | ack_onehot;
      end
      vec_valid  <= ack_take && !(ack_hit && to_slave);
      cas_active <= ack_hit && to_slave;
      if (ack_take) vec_out <= vec_base | 8'(lo_idx);
      if (ack_hit) cas_sel <= pend_idx;
    end
  end
endmodule

// File: rtl/pic8_core_chk.sv
module pic8_core_chk
  import pic8_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            int_out,
  input logic            inta,
  input logic            vec_valid,
  input logic [7:0]      vec_out,
  input logic            cas_active,
  input logic [IDXW-1:0] pend_idx,
  input logic [NIRQ-1:0] isr,
  input logic [NIRQ-1:0] imr,
  input logic [NIRQ-1:0] ack_onehot,
  input logic            eoi_req,
  input logic            mask_wr,
  input logic [7:0]      wr_data
);
  logic blocked;
  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (i <= int'(pend_idx) && isr[i]) blocked = 1'b1;
  end

  a_r1_silent_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);
  a_r6_below_service: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !blocked);
  a_r3_vector_index: assert property (@(posedge clk) disable iff (!rst_n)
    inta && int_out |=> (vec_valid && vec_out[IDXW-1:0] == $past(pend_idx)) || cas_active);
  a_r10_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    inta && ready && !int_out |=> vec_valid && vec_out[IDXW-1:0] == IDXW'(NIRQ-1));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_active));
  a_r7_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req && !inta && (isr != '0) |=> $countones(isr) == $past($countones(isr)) - 1);
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> imr == $past(wr_data));
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_onehot));
endmodule

bind pic8_core pic8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .int_out(int_out), .inta(inta),
  .vec_valid(vec_valid), .vec_out(vec_out), .cas_active(cas_active),
  .pend_idx(pend_idx), .isr(isr), .imr(imr), .ack_onehot(ack_onehot),
  .eoi_req(eoi_req), .mask_wr(mask_wr), .wr_data(wr_data)
);

// File: tb/tb_pic8_core.sv
`timescale 1ns/1ps
module tb_pic8_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_addr = 0, trig_we = 0, inta = 0;
  logic [7:0] wr_data = 0, trig_data = 0, irq_in = 0;
  logic int_out, vec_valid, cas_active;
  logic [7:0] vec_out;
  logic [2:0] cas_sel;
  int n_chk = 0, n_err = 0;
  logic [7:0] cur_irq = 0;

  // reference state
  int m_st; bit m_ready, m_single, m_ic4, m_ltim;
  logic [7:0] m_base, m_smap, m_imr, m_isr, m_lat, m_prev, m_lvl;
  bit e_vv, e_cas, e_int; logic [7:0] e_vec; logic [2:0] e_csel;

  always #5 clk = ~clk;

  pic8_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_we(trig_we), .trig_data(trig_data), .irq_in(irq_in), .inta(inta),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
    .cas_active(cas_active), .cas_sel(cas_sel)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit would_raise(input logic [7:0] irq);
    logic [7:0] lv, rq; int p, s;
    lv = m_lvl | {8{m_ltim}};
    rq = (lv & irq) | (~lv & m_lat);
    p = lowest(rq & ~m_imr); s = lowest(m_isr);
    return m_ready && p < 8 && p < s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input logic w, input logic a, input logic [7:0] d,
                            input logic lw, input logic [7:0] ld, input logic ak);
    logic [7:0] lv, rq, n_isr, n_lat, n_imr; int p, s; bit pres;
    lv = m_lvl | {8{m_ltim}};
    rq = (lv & cur_irq) | (~lv & m_lat);
    p = lowest(rq & ~m_imr); s = lowest(m_isr);
    pres = m_ready && p < 8 && p < s;
    n_isr = m_isr; n_lat = m_lat; n_imr = m_imr;
    e_vv = 0; e_cas = 0;
    if (m_ready && w && !a && d == 8'h20 && s < 8) n_isr[s] = 1'b0;
    if (m_ready && w && a) n_imr = d;
    if (m_ready && ak) begin
      if (pres) begin
        n_isr[p] = 1'b1; n_lat[p] = 1'b0;
        if (!m_single && m_smap[p]) begin e_cas = 1; e_csel = 3'(p); end
        else begin e_vv = 1; e_vec = m_base | 8'(p); end
      end else begin
        e_vv = 1; e_vec = m_base | 8'd7;
      end
    end
    n_lat = n_lat | (cur_irq & ~m_prev & ~lv);
    m_prev = cur_irq;
    if (w && !a && d[4]) begin
      m_st = 1; m_single = d[1]; m_ic4 = d[0]; m_ltim = d[3];
      n_imr = 0; n_isr = 0; n_lat = 0;
    end else if (w && a) begin
      case (m_st)
        1: begin m_base = d & 8'hF8; m_st = !m_single ? 2 : (m_ic4 ? 3 : 4); end
        2: begin m_smap = d; m_st = m_ic4 ? 3 : 4; end
        3: m_st = 4;
        default: ;
      endcase
    end
    m_ready = (m_st == 4);
    m_isr = n_isr; m_lat = n_lat; m_imr = n_imr;
    if (lw) m_lvl = ld;
    e_int = would_raise(cur_irq);
  endtask

  task automatic step(input string tag, input logic w, input logic a, input logic [7:0] d,
                      input logic lw, input logic [7:0] ld, input logic ak);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; trig_we = lw; trig_data = ld; inta = ak; irq_in = cur_irq;
    @(posedge clk);
    model_edge(w, a, d, lw, ld, ak);
    #1;
    chk(tag, "int_out", {7'b0, int_out}, {7'b0, e_int});
    chk(tag, "vec_valid", {7'b0, vec_valid}, {7'b0, e_vv});
    chk(tag, "cas_active", {7'b0, cas_active}, {7'b0, e_cas});
    if (e_vv) chk(tag, "vec_out", vec_out, e_vec);
    if (e_cas) chk(tag, "cas_sel", {5'b0, cas_sel}, {5'b0, e_csel});
  endtask

  task automatic wr(input string tag, input logic a, input logic [7:0] d); step(tag, 1, a, d, 0, 0, 0); endtask
  task automatic ack(input string tag); step(tag, 0, 0, 0, 0, 0, 1); endtask
  task automatic idle(input string tag); step(tag, 0, 0, 0, 0, 0, 0); endtask
  task automatic trig(input string tag, input logic [7:0] d); step(tag, 0, 0, 0, 1, d, 0); endtask
  task automatic lines(input string tag, input logic [7:0] v); cur_irq = v; idle(tag); endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    m_st = 0; m_ready = 0; m_single = 0; m_ic4 = 0; m_ltim = 0;
    m_base = 0; m_smap = 0; m_imr = 0; m_isr = 0; m_lat = 0; m_prev = 0; m_lvl = 0;
    e_csel = 0; e_vec = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset int_out", {7'b0, int_out}, 8'h00);
    chk("R1", "reset vec_valid", {7'b0, vec_valid}, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // R1: silent before and during initialisation, stray words ignored
    lines("R1", 8'h01);
    wr("R1", 1, 8'h55);
    wr("R1", 0, 8'h11);
    wr("R1", 0, 8'h20);
    wr("R1", 1, 8'h43);
    chk("R1", "int_out mid-init", {7'b0, int_out}, 8'h00);
    wr("R11", 1, 8'h04);
    wr("R1", 1, 8'h01);
    // R2 / R8: latch cleared by start word, held-high line does not retrigger
    idle("R2");
    chk("R2", "no request after start word", {7'b0, int_out}, 8'h00);

    // R8 / R4 / R3 / R6 / R7
    lines("R8", 8'h08);
    chk("R8", "edge on line 3", {7'b0, int_out}, 8'h01);
    lines("R4", 8'h0A);
    ack("R3");
    chk("R3", "vector line 1", vec_out, 8'h41);
    chk("R6", "line 3 held by line 1", {7'b0, int_out}, 8'h00);
    wr("R7", 0, 8'h20);
    chk("R7", "line 3 released", {7'b0, int_out}, 8'h01);
    ack("R3");
    chk("R3", "vector line 3", vec_out, 8'h43);
    wr("R7", 0, 8'h20);

    // R5: masked edge stays latched
    wr("R5", 1, 8'h10);
    lines("R5", 8'h1A);
    chk("R5", "masked line 4", {7'b0, int_out}, 8'h00);
    wr("R5", 1, 8'h00);
    chk("R5", "unmasked latched line 4", {7'b0, int_out}, 8'h01);
    ack("R5");
    lines("R6", 8'h3A);
    chk("R6", "line 5 below line 4 in service", {7'b0, int_out}, 8'h00);
    wr("R7", 0, 8'h0B);
    chk("R7", "non-EOI word keeps service", {7'b0, int_out}, 8'h00);
    wr("R7", 0, 8'h20);
    chk("R7", "EOI frees line 5", {7'b0, int_out}, 8'h01);
    ack("R3");
    chk("R3", "vector line 5", vec_out, 8'h45);
    wr("R7", 0, 8'h20);

    // R11: cascade line 2
    lines("R11", 8'h3E);
    ack("R11");
    chk("R11", "cas_active", {7'b0, cas_active}, 8'h01);
    chk("R11", "cas_sel", {5'b0, cas_sel}, 8'h02);
    chk("R11", "no vector", {7'b0, vec_valid}, 8'h00);
    wr("R7", 0, 8'h20);

    // R10: spurious acknowledge
    ack("R10");
    chk("R10", "spurious vector", vec_out, 8'h47);
    idle("R10");
    chk("R10", "no service taken", {7'b0, int_out}, 8'h00);

    // R9: level line 6
    lines("R9", 8'h00);
    trig("R9", 8'h40);
    lines("R9", 8'h40);
    chk("R9", "level request", {7'b0, int_out}, 8'h01);
    lines("R9", 8'h00);
    chk("R9", "level drop", {7'b0, int_out}, 8'h00);
    lines("R9", 8'h40);
    ack("R9");
    chk("R9", "vector line 6", vec_out, 8'h46);
    wr("R9", 0, 8'h20);
    chk("R9", "level re-request", {7'b0, int_out}, 8'h01);
    lines("R9", 8'h00);

    // R8: held-high edge line 7
    lines("R8", 8'h80);
    ack("R8");
    chk("R8", "vector line 7", vec_out, 8'h47);
    wr("R8", 0, 8'h20);
    idle("R8");
    chk("R8", "held high no retrigger", {7'b0, int_out}, 8'h00);

    // R2 / R9 / R11: reinit single, all level, no mode word
    wr("R2", 1, 8'hFF);
    lines("R2", 8'h84);
    wr("R2", 0, 8'h1A);
    wr("R11", 1, 8'h80);
    chk("R2", "mask cleared, all level", {7'b0, int_out}, 8'h01);
    ack("R11");
    chk("R11", "single mode vector", vec_out, 8'h82);
    chk("R11", "single mode no cascade", {7'b0, cas_active}, 8'h00);

    // random traffic against the model
    lines("R1", 8'h00);
    wr("R1", 0, 8'h11);
    wr("R1", 1, 8'h43);
    wr("R11", 1, 8'h04);
    wr("R1", 1, 8'h01);
    trig("R9", 8'h20);
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] flip; int op;
      flip = 0;
      for (int b = 0; b < 8; b++) if ($urandom % 8 == 0) flip[b] = 1'b1;
      cur_irq = cur_irq ^ flip;
      op = $urandom % 16;
      case (op)
        0, 1, 2: ack("R4");
        3, 4:    wr("R7", 0, 8'h20);
        5:       wr("R5", 1, 8'($urandom) & 8'($urandom));
        6:       trig("R9", 8'($urandom) & 8'($urandom));
        7:       wr("R7", 0, 8'h0B);
        default: idle("R6");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule